// File: doc/BRIEF.md
# Core Regulator Power-Up Sequencer

This block runs the power-up sequence of a two-phase core voltage regulator in the digital domain. It does nothing until the supply-good flag and the enable input are both high. It then waits a fixed delay and ramps a digital reference code slowly from zero up to a fixed boot level. Each time a PWM cycle strobe arrives, the block checks whether the sampled output voltage lies inside a window around the boot level, and it counts how many of these checks pass in a row. When that count reaches the qualifying number, the block pulls its active-low clock-enable output low. From then on the reference slews quickly toward the level chosen by a 7-bit voltage-identification code, and it follows that code as the code changes.

A long fixed delay after clock-enable falls, power-good rises. A forced two-phase continuous-conduction override stays high for the whole start-up phase. If either qualifying input falls, the block drops back to idle on the next clock. All voltages are unsigned codes in 0.5 mV units. Every timing step is paced by a microsecond tick, which a parameterised divider derives from the clock.

Top module: `vreg_startup_seq`

## Requirements
- R1: While `enable` or `supply_ok` is low, the block is idle. One clock after either input falls, `vref_code` is 0, `clk_en_n` is 1, `pwr_good` is 0 and `force_2ph_ccm` is 0.
- R2: The sequence starts only when `enable` and `supply_ok` are both high. After that, `vref_code` stays at 0 for START_DLY_US microsecond ticks.
- R3: After the start delay, `vref_code` rises by RAMP_STEP (4 units, i.e. 2 mV) per microsecond tick. It stops exactly at BOOT_REF (2400, i.e. 1.2 V).
- R4: `force_2ph_ccm` is high from the start of the sequence until `clk_en_n` falls, and low at every other time.
- R5: Once the ramp has started, each cycle of `pwm_strobe` counts as in-window when `vout_sense` lies in [BOOT_REF-WIN_REF, BOOT_REF+WIN_REF], which is [2160, 2640]. A strobe with `vout_sense` outside that range resets the count to zero. `clk_en_n` goes low on the clock after the WIN_CYCLES-th (13th) consecutive in-window strobe.
- R6: While `clk_en_n` is low, `vref_code` moves toward the VID target by SLEW_STEP (20 units, i.e. 10 mV) per tick, either up or down. It ends exactly on the target and tracks later changes of `vid_code`.
- R7: The VID target is 3000 − 25·`vid_code` (that is, 1.5 V − 12.5 mV per step). Any code whose result would be negative (120 and above) gives 0. For example, code 0 gives 3000, code 0x60 gives 600 and code 0x7F gives 0.
- R8: `pwr_good` rises PG_DLY_US ticks after `clk_en_n` falls, is never high while `clk_en_n` is high, and stays high until the block goes idle.
- R9: Going idle clears the in-window count, so a restarted sequence needs WIN_CYCLES fresh consecutive in-window strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Regulator enable |
| supply_ok | input | 1 | Controller supply above its power-on-reset threshold |
| pwm_strobe | input | 1 | One-cycle pulse per PWM switching cycle |
| vout_sense | input | REF_W | Sampled output voltage, 0.5 mV units |
| vid_code | input | VID_W | Voltage-identification code |
| vref_code | output | REF_W | Reference voltage code, 0.5 mV units |
| clk_en_n | output | 1 | Active-low clock enable; low once the boot level has qualified |
| pwr_good | output | 1 | Power-good |
| force_2ph_ccm | output | 1 | Forces two-phase continuous conduction during start-up |

## Verification
The case that is hardest to reach is the restart of the in-window count. To reach it, a run of twelve good strobes is broken by one strobe outside the window. The bench also checks that a count of twelve does not survive a drop to idle. The bench drives `vout_sense` as a level independent of the reference. This lets it place each strobe exactly on either side of the window edges, 2640 and 2641. It then shows that `clk_en_n` falls only on the thirteenth strobe of an unbroken run. The VID table walk and the up and down slope measurements both start from a finished qualification. The bench runs with short delays so that the 7 ms power-good wait fits in the run.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RAMP = 2'd2,
      ST_SLEW = 2'd3
   } seq_state_e;
endpackage

// File: rtl/vseq_tick.sv
module vseq_tick #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 1) begin : g_bad_div
      $error("vseq_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick = ~clr;
   end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     cnt <= '0;
         else if (clr)                   cnt <= '0;
         else if (cnt == CW'(DIV - 1))   cnt <= '0;
         else                            cnt <= cnt + 1'b1;
      end
      assign tick = ~clr && (cnt == CW'(DIV - 1));
   end
endmodule

// File: rtl/vseq_vid_map.sv
module vseq_vid_map #(
   parameter int VID_W   = 7,
   parameter int REF_W   = 12,
   parameter int MAX_REF = 3000,
   parameter int LSB_REF = 25
) (
   input  logic [VID_W-1:0] code,
   output logic [REF_W-1:0] target
);
   if (MAX_REF >= (1 << REF_W)) begin : g_bad_max
      $error("vseq_vid_map: MAX_REF does not fit REF_W");
   end

   int drop;
   always_comb begin
      drop = int'(code) * LSB_REF;
      if (drop >= MAX_REF) target = '0;
      else                 target = REF_W'(MAX_REF - drop);
   end
endmodule

// File: rtl/vseq_stepper.sv
module vseq_stepper #(
   parameter int REF_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [REF_W-1:0] step,
   input  logic [REF_W-1:0] target,
   output logic [REF_W-1:0] ref_o
);
   function automatic logic [REF_W-1:0] gap(input logic [REF_W-1:0] a, input logic [REF_W-1:0] b);
      return (a > b) ? a - b : b - a;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ref_o <= '0;
      else if (clr) ref_o <= '0;
      else if (adv) begin
         if (ref_o < target)
            ref_o <= (target - ref_o <= step) ? target : ref_o + step;
         else if (ref_o > target)
            ref_o <= (ref_o - target <= step) ? target : ref_o - step;
      end
   end

   // R3 and R6: each move is bounded by the step and never passes the target
   assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> gap(ref_o, $past(ref_o)) <= $past(step));
   assert_no_overshoot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ref_o <= target) |=> ($past(target) != target) || ref_o <= target);
endmodule

// File: rtl/vreg_startup_seq.sv
module vreg_startup_seq
   import vseq_pkg::*;
#(
   parameter int REF_W        = 12,
   parameter int VID_W        = 7,
   parameter int TICKS_PER_US = 100,
   parameter int START_DLY_US = 100,
   parameter int PG_DLY_US    = 7000,
   parameter int BOOT_REF     = 2400,
   parameter int VID_MAX_REF  = 3000,
   parameter int VID_LSB_REF  = 25,
   parameter int RAMP_STEP    = 4,
   parameter int SLEW_STEP    = 20,
   parameter int WIN_REF      = 240,
   parameter int WIN_CYCLES   = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             supply_ok,
   input  logic             pwm_strobe,
   input  logic [REF_W-1:0] vout_sense,
   input  logic [VID_W-1:0] vid_code,
   output logic [REF_W-1:0] vref_code,
   output logic             clk_en_n,
   output logic             pwr_good,
   output logic             force_2ph_ccm
);
   localparam int DW = $clog2(START_DLY_US + 1);
   localparam int PW = $clog2(PG_DLY_US + 1);
   localparam int QW = $clog2(WIN_CYCLES + 1);
   localparam logic [REF_W-1:0] WIN_LO = REF_W'(BOOT_REF - WIN_REF);
   localparam logic [REF_W-1:0] WIN_HI = REF_W'(BOOT_REF + WIN_REF);

   if (START_DLY_US < 1 || PG_DLY_US < 1 || WIN_CYCLES < 1) begin : g_bad_time
      $error("vreg_startup_seq: delays and window count must be at least 1");
   end
   if (WIN_REF > BOOT_REF || BOOT_REF + WIN_REF >= (1 << REF_W)) begin : g_bad_win
      $error("vreg_startup_seq: boot window does not fit REF_W");
   end
   if (RAMP_STEP < 1 || SLEW_STEP < 1) begin : g_bad_step
      $error("vreg_startup_seq: steps must be positive");
   end

   seq_state_e       state;
   logic             run, tick, in_win, pg_q;
   logic [DW-1:0]    dly_cnt;
   logic [PW-1:0]    pg_cnt;
   logic [QW-1:0]    qual_cnt;
   logic [REF_W-1:0] vid_tgt, step_sel, tgt_sel;

   assign run    = enable & supply_ok;
   assign in_win = (vout_sense >= WIN_LO) && (vout_sense <= WIN_HI);

   vseq_tick #(.DIV(TICKS_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(!run || state == ST_IDLE), .tick(tick));

   vseq_vid_map #(.VID_W(VID_W), .REF_W(REF_W), .MAX_REF(VID_MAX_REF), .LSB_REF(VID_LSB_REF))
      u_vid (.code(vid_code), .target(vid_tgt));

   assign step_sel = (state == ST_SLEW) ? REF_W'(SLEW_STEP) : REF_W'(RAMP_STEP);
   assign tgt_sel  = (state == ST_SLEW) ? vid_tgt : REF_W'(BOOT_REF);

   vseq_stepper #(.REF_W(REF_W)) u_step (
      .clk(clk), .rst_n(rst_n),
      .clr(!run || state == ST_IDLE || state == ST_WAIT),
      .adv(tick && (state == ST_RAMP || state == ST_SLEW)),
      .step(step_sel), .target(tgt_sel), .ref_o(vref_code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; dly_cnt <= '0; qual_cnt <= '0; pg_cnt <= '0; pg_q <= 1'b0;
      end else if (!run) begin
         state <= ST_IDLE; dly_cnt <= '0; qual_cnt <= '0; pg_cnt <= '0; pg_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               state   <= ST_WAIT;
               dly_cnt <= '0;
            end
            ST_WAIT: if (tick) begin
               if (dly_cnt == DW'(START_DLY_US - 1)) state <= ST_RAMP;
               else                                  dly_cnt <= dly_cnt + 1'b1;
            end
            ST_RAMP: if (pwm_strobe) begin
               if (!in_win) qual_cnt <= '0;
               else if (qual_cnt == QW'(WIN_CYCLES - 1)) begin
                  qual_cnt <= '0;
                  state    <= ST_SLEW;
               end else qual_cnt <= qual_cnt + 1'b1;
            end
            ST_SLEW: if (tick && !pg_q) begin
               if (pg_cnt == PW'(PG_DLY_US - 1)) pg_q   <= 1'b1;
               else                              pg_cnt <= pg_cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign clk_en_n      = (state != ST_SLEW);
   assign pwr_good      = pg_q;
   assign force_2ph_ccm = (state == ST_WAIT) || (state == ST_RAMP);

   assert_abort_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (vref_code == '0) && clk_en_n && !pwr_good && !force_2ph_ccm);
   assert_force_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      force_2ph_ccm |-> clk_en_n);
   assert_clken_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en_n) |-> $past(pwm_strobe) && $past(in_win));
   assert_pg_after_clken_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_good |-> !clk_en_n);
   assert_pg_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_good && run) |=> pwr_good);
endmodule

// File: tb/vreg_startup_seq_bench.sv
module vreg_startup_seq_bench;
   localparam int REF_W = 12;
   localparam int TPU   = 2;

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, supply_ok = 1'b0, pwm_strobe = 1'b0;
   logic [REF_W-1:0] vout_sense = '0;
   logic [6:0]       vid_code = '0;
   logic [REF_W-1:0] vref_code;
   logic clk_en_n, pwr_good, force_2ph_ccm;
   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   vreg_startup_seq #(.TICKS_PER_US(TPU), .START_DLY_US(4), .PG_DLY_US(20)) u_vreg_startup_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable), .supply_ok(supply_ok),
      .pwm_strobe(pwm_strobe), .vout_sense(vout_sense), .vid_code(vid_code),
      .vref_code(vref_code), .clk_en_n(clk_en_n), .pwr_good(pwr_good),
      .force_2ph_ccm(force_2ph_ccm));

   localparam int NV = 11;
   localparam int VCODE [NV] = '{0, 1, 5, 17, 28, 53, 59, 96, 127, 120, 119};
   localparam int VEXP  [NV] = '{3000, 2975, 2875, 2575, 2300, 1675, 1525, 600, 0, 0, 25};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(input int v, input int n);
      vout_sense = REF_W'(v);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) pwm_strobe = 1'b1;
         @(negedge clk) pwm_strobe = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      finish_run();
   end

   initial begin
      int a, b, t_fall;
      cyc(3); rst_n = 1'b1; cyc(2);
      // R1 reset/idle state
      chk("R1 ref", vref_code, 0); chk("R1 clk_en_n", clk_en_n, 1);
      chk("R1 pg", pwr_good, 0);   chk("R1 force", force_2ph_ccm, 0);

      // R2 enable alone does not start
      enable = 1'b1; cyc(50);
      chk("R2 no start force", force_2ph_ccm, 0); chk("R2 no start ref", vref_code, 0);

      supply_ok = 1'b1; cyc(2);
      chk("R4 force at start", force_2ph_ccm, 1);
      cyc(3);
      chk("R2 ref held during delay", vref_code, 0);
      cyc(95);
      a = int'(vref_code); cyc(2*TPU); b = int'(vref_code);
      chk("R3 ramp slope", b - a, 2*4);
      cyc(1400);
      chk("R3 boot level", vref_code, 2400);
      chk("R5 no strobe no enable", clk_en_n, 1);

      // R5 window qualification
      vid_code = 7'h60;
      strobe(2641, 20); chk("R5 above window", clk_en_n, 1);
      strobe(2159, 5);  chk("R5 below window", clk_en_n, 1);
      strobe(2640, 12); strobe(3000, 1); strobe(2160, 12);
      chk("R5 restart after miss", clk_en_n, 1);
      chk("R4 force before qualify", force_2ph_ccm, 1);
      strobe(2400, 1);
      chk("R5 thirteenth strobe", clk_en_n, 0);
      chk("R4 force after qualify", force_2ph_ccm, 0);
      t_fall = 0;

      // R6 slew down
      cyc(10); t_fall += 10;
      a = int'(vref_code); cyc(2*TPU); t_fall += 2*TPU; b = int'(vref_code);
      chk("R6 slew down", a - b, 2*20);
      cyc(30 - t_fall);
      chk("R8 pg still low", pwr_good, 0);
      cyc(20);
      chk("R8 pg high", pwr_good, 1);
      cyc(200);
      chk("R6 settle down", vref_code, 600);

      // R6 slew up
      vid_code = 7'h00; cyc(10);
      a = int'(vref_code); cyc(2*TPU); b = int'(vref_code);
      chk("R6 slew up", b - a, 2*20);

      // R7 table walk
      for (int i = 0; i < NV; i++) begin
         vid_code = 7'(VCODE[i]); cyc(400);
         chk($sformatf("R7 vid %0d", VCODE[i]), vref_code, VEXP[i]);
      end
      chk("R8 pg holds", pwr_good, 1);

      // R1 abort
      supply_ok = 1'b0; cyc(1);
      chk("R1 abort ref", vref_code, 0); chk("R1 abort clk_en_n", clk_en_n, 1);
      chk("R1 abort pg", pwr_good, 0);

      // R9 count cleared by abort
      supply_ok = 1'b1; cyc(20);
      strobe(2400, 12);
      enable = 1'b0; cyc(2); enable = 1'b1; cyc(20);
      strobe(2400, 1);
      chk("R9 count cleared", clk_en_n, 1);
      strobe(2400, 12);
      chk("R9 fresh thirteen", clk_en_n, 0);
      finish_run();
   end
endmodule